// File: doc/BRIEF.md
# Programmable Two-Input Logic Cell Array

This block is a fabric of sixteen tiny logic cells for building glue logic in software. Each cell owns one word-aligned configuration register. In that register, software picks where each of the cell's two operands comes from and which of the sixteen two-input Boolean functions joins them. It also picks whether the cell's output pin shows the combinational result or a registered copy of it.

Operand A is either a feedback tap or the cell's bit in a shared data register. Operand B is either the cell's own input pin or a second feedback tap. Each feedback tap selects, through a 2-bit field, the flip-flop of one of the four cells that follow the cell in ring order. Every cell's flip-flop captures the function result on every rising clock edge. This happens whether or not the output pin bypasses the flip-flop. As a result, feedback paths between cells always pass through a register and can never form a combinational loop.

A plain single-cycle write port and an address-decoded combinational read port give access to the seventeen registers.

Top module: `lutmx_array`

## Requirements
- R1: While reset is applied, and after it is released, every configuration register, the data register and every cell flip-flop is zero. Every output pin is therefore zero until software writes a register.
- R2: The word index is taken from bus_addr[6:2], and bus_addr[1:0] are ignored. Index n from 0 to 15 selects cell n's configuration register, which stores bits 10:0. Index 16 selects the data register, which stores bits 15:0. A read returns the stored bits with every other bit zero. Reads of indices above 16 return zero. Writes to bits that are not stored, and writes to indices above 16, change nothing.
- R3: Configuration bits 4:1 hold the function code. Code 0 gives 0 and code 15 gives 1. Codes 1 to 14 give, in order: NOR, B&~A, ~A, A&~B, ~B, XOR, NAND, AND, XNOR, B, ~A|B, A, A|~B, OR.
- R4: Configuration bit 6 picks operand A. A value of 1 takes the first feedback tap. A value of 0 takes bit n of the data register for cell n.
- R5: Configuration bit 5 picks operand B. A value of 1 takes pin_in[n]. A value of 0 takes the second feedback tap.
- R6: Configuration bits 10:9 select the first feedback tap and bits 8:7 select the second. A value of k selects the flip-flop of cell (n+k+1) mod 16.
- R7: With configuration bit 0 set to 1, pin_out[n] equals the function result in the same cycle as its operands.
- R8: With configuration bit 0 set to 0, pin_out[n] shows the flip-flop. The flip-flop shows the function result one rising edge after the operands are applied.
- R9: A cell's flip-flop captures its function result on every rising edge, including while configuration bit 0 is 1. Other cells read this flip-flop through their feedback taps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 16 | External input bit for each cell |
| pin_out | output | 16 | Output bit of each cell |

## Verification
The assertions assume that pin_in and the bus inputs are synchronous to clk and settle well before each rising edge. No pin synchronizer is present. They also assume that no write is issued while the internal reset is still held after rst_n rises. The stimulus changes every input on the falling edge only. It waits several cycles after reset release before the first write. After that point, the reference model in the bench and the design agree on all state, because every register is still zero.

// File: rtl/lutmx_pkg.sv
package lutmx_pkg;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned TAPS   = 1 << SEL_W;
  localparam int unsigned FUNC_W = 4;
  localparam int unsigned CFG_W  = 2 * SEL_W + 2 + FUNC_W + 1;

  // Field order is the register bit order, MSB first (bits 10..0).
  typedef struct packed {
    logic [SEL_W-1:0]  sel_a;      // first feedback tap select
    logic [SEL_W-1:0]  sel_b;      // second feedback tap select
    logic              a_from_tap; // 1: A from tap, 0: from data register
    logic              b_from_pin; // 1: B from pin, 0: from tap
    logic [FUNC_W-1:0] func;       // truth table, index {A,B}
    logic              comb_out;   // 1: bypass the output flip-flop
  } cell_cfg_t;
endpackage

// File: rtl/lutmx_rst_sync.sv
module lutmx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_ok = hold_q;
endmodule

// File: rtl/lutmx_cfg_regs.sv
module lutmx_cfg_regs
  import lutmx_pkg::*;
#(
  parameter int unsigned NUM_ELEM = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output cell_cfg_t [NUM_ELEM-1:0] cfg_q,
  output logic [NUM_ELEM-1:0]      din_q
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned USED_W = (NUM_ELEM > CFG_W) ? NUM_ELEM : CFG_W;

  logic [IDX_W-1:0]    word_idx;
  logic [NUM_ELEM-1:0] cfg_we;
  logic                din_we;
  cell_cfg_t           cfg_d;
  logic [NUM_ELEM-1:0] din_d;
  logic                unused_bits;

  assign word_idx    = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:USED_W]};

  // Next-state values and enables
  always_comb begin
    cfg_d  = cell_cfg_t'(bus_wdata[CFG_W-1:0]);
    din_d  = bus_wdata[NUM_ELEM-1:0];
    din_we = bus_wr && (word_idx == IDX_W'(NUM_ELEM));
  end

  for (genvar n = 0; n < NUM_ELEM; n++) begin : g_cfg
    assign cfg_we[n] = bus_wr && (word_idx == IDX_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[n] <= '0;
      end else if (cfg_we[n]) begin
        cfg_q[n] <= cfg_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
    end else if (din_we) begin
      din_q <= din_d;
    end
  end

  // Read decode
  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NUM_ELEM; n++) begin
      if (word_idx == IDX_W'(n)) begin
        bus_rdata[CFG_W-1:0] = cfg_q[n];
      end
    end
    if (word_idx == IDX_W'(NUM_ELEM)) begin
      bus_rdata[NUM_ELEM-1:0] = din_q;
    end
  end
endmodule

// File: rtl/lutmx_cell.sv
module lutmx_cell
  import lutmx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cell_cfg_t       cfg,
  input  logic            din_bit,
  input  logic            pin_bit,
  input  logic [TAPS-1:0] taps,
  output logic            lut_o,
  output logic            ff_o,
  output logic            out_o
);
  logic tap_a;
  logic tap_b;
  logic in_a;
  logic in_b;
  logic lut_d;
  logic ff_q;

  always_comb begin
    tap_a = taps[cfg.sel_a];
    tap_b = taps[cfg.sel_b];
    in_a  = cfg.a_from_tap ? tap_a : din_bit;
    in_b  = cfg.b_from_pin ? pin_bit : tap_b;
    lut_d = cfg.func[{in_a, in_b}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else begin
      ff_q <= lut_d;
    end
  end

  assign lut_o = lut_d;
  assign ff_o  = ff_q;
  assign out_o = cfg.comb_out ? lut_d : ff_q;
endmodule

// File: rtl/lutmx_array.sv
module lutmx_array
  import lutmx_pkg::*;
#(
  parameter  int unsigned NUM_ELEM = 16,
  parameter  int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W   = $clog2((NUM_ELEM + 1) * 4)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_ELEM-1:0] pin_in,
  output logic [NUM_ELEM-1:0] pin_out
);
  logic                     rst_ok;
  cell_cfg_t [NUM_ELEM-1:0] cfg_q;
  logic [NUM_ELEM-1:0]      din_q;
  logic [NUM_ELEM-1:0]      lut_vec;
  logic [NUM_ELEM-1:0]      ff_vec;

  lutmx_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  lutmx_cfg_regs #(
    .NUM_ELEM (NUM_ELEM),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_ok),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_q     (cfg_q),
    .din_q     (din_q)
  );

  for (genvar n = 0; n < NUM_ELEM; n++) begin : g_cell
    logic [TAPS-1:0] taps;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam int unsigned SRC = (n + k + 1) % NUM_ELEM;
      assign taps[k] = ff_vec[SRC];
    end

    lutmx_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_ok),
      .cfg     (cfg_q[n]),
      .din_bit (din_q[n]),
      .pin_bit (pin_in[n]),
      .taps    (taps),
      .lut_o   (lut_vec[n]),
      .ff_o    (ff_vec[n]),
      .out_o   (pin_out[n])
    );
  end
endmodule

// File: rtl/lutmx_chk.sv
module lutmx_chk #(
  parameter int unsigned NUM_ELEM = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CFG_W    = 11
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rst_ok,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [DATA_W-1:0]            bus_rdata,
  input logic [NUM_ELEM*CFG_W-1:0]    cfg_flat,
  input logic [NUM_ELEM-1:0]          din_q,
  input logic [NUM_ELEM-1:0]          lut_vec,
  input logic [NUM_ELEM-1:0]          ff_vec,
  input logic [NUM_ELEM-1:0]          pin_out
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned USED_W = (NUM_ELEM > CFG_W) ? NUM_ELEM : CFG_W;

  logic unused_chk;
  assign unused_chk = ^{bus_addr[1:0], bus_wdata[DATA_W-1:NUM_ELEM]};

  // R1: reset clears every piece of state
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (cfg_flat == '0 && din_q == '0 && ff_vec == '0));

  // R2: a write to the data register lands on the next edge
  a_r2_din_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && $past(rst_ok) && $past(bus_wr)
     && $past(bus_addr[ADDR_W-1:2]) == IDX_W'(NUM_ELEM))
    |-> din_q == $past(bus_wdata[NUM_ELEM-1:0]));

  // R2: bits above the stored fields always read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> bus_rdata[DATA_W-1:USED_W] == '0);

  // R8: every flip-flop holds last cycle's function result
  a_r8_ff_follows_lut: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && $past(rst_ok)) |-> ff_vec == $past(lut_vec));

  for (genvar n = 0; n < NUM_ELEM; n++) begin : g_elem
    logic [3:0] func_n;
    logic       comb_n;
    assign func_n = cfg_flat[n*CFG_W+1 +: 4];
    assign comb_n = cfg_flat[n*CFG_W];

    // R3: constant codes
    a_r3_const_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (func_n == 4'h0) |-> !lut_vec[n]);
    a_r3_const_one: assert property (@(posedge clk) disable iff (!rst_n)
      (func_n == 4'hF) |-> lut_vec[n]);

    // R8: registered output lags the function result by one edge
    a_r8_out_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_ok && $past(rst_ok) && !comb_n) |-> pin_out[n] == $past(lut_vec[n]));
  end
endmodule

bind lutmx_array lutmx_chk #(
  .NUM_ELEM (NUM_ELEM),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .CFG_W    (lutmx_pkg::CFG_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_ok    (rst_ok),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cfg_flat  (cfg_q),
  .din_q     (din_q),
  .lut_vec   (lut_vec),
  .ff_vec    (ff_vec),
  .pin_out   (pin_out)
);

// File: tb/test_lutmx_array.sv
module test_lutmx_array;
  localparam int NE = 16;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;

  lutmx_array i_lutmx_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model state
  logic [10:0] m_cfg [NE];
  logic [15:0] m_din;
  logic [15:0] m_ff;
  int n_chk  = 0;
  int n_fail = 0;

  function automatic logic ref_op(logic [3:0] code, logic a, logic b);
    case (code)
      4'd0:  return 1'b0;
      4'd1:  return !(a | b);
      4'd2:  return b & !a;
      4'd3:  return !a;
      4'd4:  return a & !b;
      4'd5:  return !b;
      4'd6:  return a ^ b;
      4'd7:  return !(a & b);
      4'd8:  return a & b;
      4'd9:  return !(a ^ b);
      4'd10: return b;
      4'd11: return !a | b;
      4'd12: return a;
      4'd13: return a | !b;
      4'd14: return a | b;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic ref_lut(int n);
    logic [10:0] c;
    logic ta, tb, a, b;
    c  = m_cfg[n];
    ta = m_ff[(n + int'(c[10:9]) + 1) % NE];
    tb = m_ff[(n + int'(c[8:7]) + 1) % NE];
    a  = c[6] ? ta : m_din[n];
    b  = c[5] ? pin_in[n] : tb;
    return ref_op(c[4:1], a, b);
  endfunction

  function automatic logic [31:0] mk(int sa, int sb, int atap, int bpin, int code, int comb);
    logic [31:0] w;
    w = '0;
    w[10:9] = sa[1:0];
    w[8:7]  = sb[1:0];
    w[6]    = atap[0];
    w[5]    = bpin[0];
    w[4:1]  = code[3:0];
    w[0]    = comb[0];
    return w;
  endfunction

  function automatic logic [31:0] ref_read(logic [6:0] addr);
    int idx;
    idx = int'(addr[6:2]);
    if (idx < NE) return {21'b0, m_cfg[idx]};
    if (idx == NE) return {16'b0, m_din};
    return 32'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: compare outputs, advance the model over the rising edge.
  task automatic step(input string tag);
    logic [15:0] exp_out, nxt_ff;
    int idx;
    #1;
    for (int n = 0; n < NE; n++) begin
      nxt_ff[n]  = ref_lut(n);
      exp_out[n] = m_cfg[n][0] ? nxt_ff[n] : m_ff[n];
    end
    chk(tag, {16'b0, pin_out}, {16'b0, exp_out});
    @(posedge clk);
    m_ff = nxt_ff;
    if (bus_wr) begin
      idx = int'(bus_addr[6:2]);
      if (idx < NE) m_cfg[idx] = bus_wdata[10:0];
      else if (idx == NE) m_din = bus_wdata[15:0];
    end
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [6:0] addr, input logic [31:0] data, input string tag);
    bus_wr    = 1'b1;
    bus_addr  = addr;
    bus_wdata = data;
    step(tag);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] addr, input string tag);
    bus_addr = addr;
    #1;
    chk(tag, bus_rdata, ref_read(addr));
  endtask

  task automatic write_all(input logic [31:0] data, input string tag);
    for (int n = 0; n < NE; n++) bus_write(7'(n * 4), data, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n     = 1'b1;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    pin_in    = '0;
    for (int n = 0; n < NE; n++) m_cfg[n] = '0;
    m_din = '0;
    m_ff  = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R1 in reset", {16'b0, pin_out}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step("R1");
    for (int i = 0; i <= NE + 1; i++) bus_read(7'(i * 4), "R1 read");

    // Register map, reserved bits, out-of-range indices
    bus_write(7'h00, 32'hFFFF_FFFF, "R2");
    bus_read(7'h00, "R2 cfg");
    chk("R2 cfg value", bus_rdata, 32'h0000_07FF);
    bus_write(7'h40, 32'hFFFF_FFFF, "R2");
    bus_read(7'h40, "R2 din");
    chk("R2 din value", bus_rdata, 32'h0000_FFFF);
    bus_write(7'h44, 32'hFFFF_FFFF, "R2");
    bus_write(7'h7D, 32'h0000_0155, "R2");
    bus_read(7'h44, "R2 beyond");
    bus_read(7'h7C, "R2 beyond");
    bus_write(7'h1B, 32'h0000_0123, "R2");
    bus_read(7'h18, "R2 unaligned");
    for (int i = 0; i < NE; i++) bus_read(7'(i * 4), "R2 sweep");
    write_all(32'h0, "R2");
    bus_write(7'h40, 32'h0, "R2");

    // Function table sweep: A from data register, B from pin, bypassed
    for (int code = 0; code < 16; code++) begin
      write_all(mk(0, 0, 0, 1, code, 1), "R3");
      for (int ab = 0; ab < 4; ab++) begin
        logic [15:0] dv, pv;
        for (int n = 0; n < NE; n++) begin
          int v;
          v = (ab + n) % 4;
          dv[n] = v[1];
          pv[n] = v[0];
        end
        bus_write(7'h40, {16'b0, dv}, "R4");
        pin_in = pv;
        step("R3");
        step("R5");
        bus_read(7'h40, "R4 din readback");
      end
    end
    pin_in = '0;

    // Registered path latency on cell 0
    write_all(32'h0, "R8");
    bus_write(7'h40, 32'h0, "R8");
    bus_write(7'h00, mk(0, 0, 0, 0, 12, 0), "R8");
    step("R8");
    bus_write(7'h40, 32'h1, "R8");
    #1 chk("R8 old value held", {31'b0, pin_out[0]}, 32'h0);
    step("R8");
    #1 chk("R8 new value after edge", {31'b0, pin_out[0]}, 32'h1);
    step("R8");

    // Bypass follows operands in the same cycle on cell 1
    bus_write(7'h04, mk(0, 0, 0, 1, 8, 1), "R7");
    bus_write(7'h40, 32'h2, "R7");
    pin_in = 16'h0002;
    #1 chk("R7 same-cycle", {31'b0, pin_out[1]}, 32'h1);
    step("R7");
    pin_in = 16'h0000;
    #1 chk("R7 same-cycle low", {31'b0, pin_out[1]}, 32'h0);
    step("R7");

    // Feedback rings through the first tap, then through the second
    for (int s = 0; s < 4; s++) begin
      write_all(mk(0, 0, 0, 0, 12, 0), "R6");
      bus_write(7'h40, 32'h0000_8421 << s, "R6");
      step("R6");
      write_all(mk(s, 0, 1, 0, 12, 0), "R4");
      repeat (20) step("R6");
      write_all(mk(0, s, 0, 0, 10, 0), "R5");
      repeat (20) step("R6");
    end

    // Bypassed cells still clock their flip-flops into the feedback taps
    write_all(mk(0, 0, 0, 0, 12, 0), "R9");
    bus_write(7'h40, 32'h0000_0011, "R9");
    step("R9");
    write_all(mk(0, 0, 1, 0, 12, 1), "R9");
    repeat (24) step("R9");

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      pin_in = 16'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        bus_write(7'($urandom_range(0, 127)), $urandom, "R7");
      end else begin
        step("R8");
      end
    end
    for (int i = 0; i < 32; i++) bus_read(7'(i * 4), "R2 final");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule